// File: doc/BRIEF.md
# Serial Command Decoder with Control Registers

This block interprets the command stream that a host microcontroller sends over a serial slave link. A separate byte-level receiver delivers each byte as a one-cycle `rxValid` pulse. A transmit shifter fetches the reply for the next byte slot from `txByte`. The chip select level is `csActive`, which is high while the host frames a command. The first byte of each frame is an opcode. The high nibble of the opcode picks the operation and the low nibble carries a small argument. Parameter bytes or dummy bytes follow, depending on the command.

Decoded commands load a set of control registers:
- a RAM address, two 16-bit buffer addresses and two 24-bit address masks
- a mapper code
- a DMA start/end window
- a playback volume, a playing flag and an 8-bit status byte

Other commands produce one-cycle strobes for neighbouring blocks: start a DMA, clear the playback pointer, latch a volume, and read or write one RAM byte. Readback commands return a test token, a status word, a 32-bit data offset, a track number or a volume, most significant byte first. An echo command returns every byte one slot later.

Multi-byte values are committed only when the last byte of their command arrives. Dropping chip select before that discards the sequence. Bytes arrive at least three clock cycles apart.

Top module: `spiCmdDecoder`

## Requirements
- R1: After reset every register output is zero, `txByte` is 0x00 and no strobe is high.
- R2: Opcode 0x00 followed by three bytes loads `ramAddr`, high byte first. Opcodes 0x01 and 0x02 followed by two bytes load `audioAddr` and `dataAddr`. Each value changes only when its last byte arrives.
- R3: Opcodes 0x10 and 0x20, each followed by three bytes sent high byte first, load `romMask` and `saveMask`.
- R4: Opcode 0x3m sets `mapper` to m[2:0]. Opcode 0x4s pulses `dmaGo` for exactly one cycle and sets `dmaPartial` to s[2] and `dmaTarget` to s[1:0].
- R5: Opcode 0x60 followed by four bytes loads `dmaStart` from bytes 1–2 and `dmaEnd` from bytes 3–4, each high byte first.
- R6: Opcode 0x50 takes a volume byte and then two dummy bytes. `volume` takes the value only when the second dummy byte arrives, together with a one-cycle `volStrobe`.
- R7: Opcode 0xE0 takes a set mask and then a clear mask. After the clear mask, `statusLo` becomes (old | set) & ~clear, so clear wins on a shared bit.
- R8: Opcode 0xE2 sets `playing`. Opcode 0xE1 clears it. Opcode 0xE3 pulses `ptrClear` for one cycle.
- R9: Readback. The reply in the slot after each byte is as follows:
  - After 0xF0 the reply is the token 0xA5.
  - After 0xF1 the replies repeat `statusHiIn`, `statusLo` for as long as bytes continue.
  - After 0xF2 the replies are the four bytes of `offsetIn`, high byte first.
  - After 0xF3 the replies are the two bytes of `trackIn`, high byte first.
  - After 0xF4 the reply is `volumeIn`.
  - Once the value is exhausted, every further reply is 0x00.
- R10: After opcode 0xFF, the reply following each later byte equals that byte. The opcode slot itself replies 0x00.
- R11: Opcodes 0x80 and 0x81 pulse `memRd` on the opcode and on every later byte, and the next reply is `memRdData`. Opcodes 0x90 and 0x91 pulse `memWr` with `memWrData` on every later byte. The address is `ramAddr` during the pulse. Opcodes 0x80 and 0x90 increment `ramAddr` after each access; 0x81 and 0x91 leave it unchanged.
- R12: Dropping `csActive` aborts a partly received command without changing any register. The next byte is decoded as an opcode.
- R13: An opcode not listed above changes no register and replies 0x00 to all its bytes.
- R14: Bytes beyond a command's parameter count are ignored and are not decoded as opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csActive | input | 1 | Chip select, high while a command is framed |
| rxValid | input | 1 | One-cycle pulse: received byte valid |
| rxByte | input | 8 | Received byte |
| txByte | output | 8 | Reply for the next byte slot |
| ramAddr | output | 24 | RAM address, also the access address |
| audioAddr | output | 16 | Audio buffer address |
| dataAddr | output | 16 | Data buffer address |
| romMask | output | 24 | Input address mask |
| saveMask | output | 24 | Save RAM address mask |
| mapper | output | 3 | Mapper code |
| dmaGo | output | 1 | DMA start strobe |
| dmaPartial | output | 1 | DMA partial-transfer flag |
| dmaTarget | output | 2 | DMA target |
| dmaStart | output | 16 | DMA window start offset |
| dmaEnd | output | 16 | DMA window end offset |
| volume | output | 8 | Latched playback volume |
| volStrobe | output | 1 | Volume latch strobe |
| playing | output | 1 | Playback running |
| ptrClear | output | 1 | Playback pointer clear strobe |
| statusLo | output | 8 | Low status byte |
| statusHiIn | input | 8 | High status byte for readback |
| trackIn | input | 16 | Track number for readback |
| offsetIn | input | 32 | Data offset for readback |
| volumeIn | input | 8 | Volume for readback |
| memRd | output | 1 | RAM read strobe |
| memWr | output | 1 | RAM write strobe |
| memWrData | output | 8 | RAM write data |
| memRdData | input | 8 | RAM read data, valid the cycle after `memRd` |

## Verification
Most internal faults in this block first show up as a wrong reply byte, and they show up one byte slot later. Examples are a stale opcode, a parameter counter that is off by one, or a wrong readback index. For that reason every byte sent carries an expected reply.

A counter that commits one byte early or late is caught differently. The register is compared in the middle of the frame, before the last byte, and again after it. A missed abort on chip-select drop leaves a register changed after the next frame. A strobe held too long shows up as an extra pulse counted at the port.

// File: rtl/spiCmdPkg.sv
package spiCmdPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 24;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    TX_ZERO, TX_TOKEN, TX_STATUS, TX_OFFSET, TX_TRACK, TX_VOLUME, TX_ECHO
  } txSel_e;

  typedef struct packed {
    logic   accShift;
    logic   setRamAddr;
    logic   setAudioAddr;
    logic   setDataAddr;
    logic   setRomMask;
    logic   setSaveMask;
    logic   setMapper;
    logic   setWindow;
    logic   setVolume;
    logic   setStatus;
    logic   kickDma;
    logic   playOn;
    logic   playOff;
    logic   ptrZero;
    logic   memRead;
    logic   memWrite;
    logic   incMode;
    logic   txLoad;
    txSel_e txSel;
    logic [1:0] txIdx;
  } ctlStrobes_t;
endpackage

// File: rtl/spiCmdCtl.sv
module spiCmdCtl
  import spiCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output ctlStrobes_t       ctl,
  output logic              readMode
);
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              busy;
  logic [BYTE_W-1:0] opcode;
  logic [CNT_W-1:0]  cnt;
  logic              phase;
  logic              take;

  assign take     = rxValid && csActive;
  assign readMode = busy && (opcode[7:1] == 7'b1000000);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      opcode <= '0;
      cnt    <= '0;
      phase  <= 1'b0;
    end else if (!csActive) begin
      busy <= 1'b0;
    end else if (rxValid) begin
      if (!busy) begin
        busy   <= 1'b1;
        opcode <= rxByte;
        cnt    <= '0;
        phase  <= 1'b0;
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        phase <= ~phase;
      end
    end
  end

  always_comb begin
    ctl        = '0;
    ctl.txSel  = TX_ZERO;
    ctl.txLoad = take;
    if (take) begin
      if (!busy) begin
        unique case (rxByte[7:4])
          4'h3: ctl.setMapper = 1'b1;
          4'h4: ctl.kickDma   = 1'b1;
          4'h8: begin
            if (rxByte[3:1] == 3'b000) begin
              ctl.memRead = 1'b1;
              ctl.incMode = !rxByte[0];
            end
          end
          4'hE: begin
            unique case (rxByte[3:0])
              4'h1:    ctl.playOff = 1'b1;
              4'h2:    ctl.playOn  = 1'b1;
              4'h3:    ctl.ptrZero = 1'b1;
              default: ;
            endcase
          end
          4'hF: begin
            unique case (rxByte[3:0])
              4'h0:    ctl.txSel = TX_TOKEN;
              4'h1:    ctl.txSel = TX_STATUS;
              4'h2:    ctl.txSel = TX_OFFSET;
              4'h3:    ctl.txSel = TX_TRACK;
              4'h4:    ctl.txSel = TX_VOLUME;
              default: ctl.txSel = TX_ZERO;
            endcase
          end
          default: ;
        endcase
      end else begin
        ctl.accShift = 1'b1;
        unique case (opcode)
          8'h00: ctl.setRamAddr   = (cnt == 3'd2);
          8'h01: ctl.setAudioAddr = (cnt == 3'd1);
          8'h02: ctl.setDataAddr  = (cnt == 3'd1);
          8'h10: ctl.setRomMask   = (cnt == 3'd2);
          8'h20: ctl.setSaveMask  = (cnt == 3'd2);
          8'h50: ctl.setVolume    = (cnt == 3'd2);
          8'h60: ctl.setWindow    = (cnt == 3'd3);
          8'hE0: ctl.setStatus    = (cnt == 3'd1);
          8'h80, 8'h81: begin
            ctl.memRead = 1'b1;
            ctl.incMode = !opcode[0];
          end
          8'h90, 8'h91: begin
            ctl.memWrite = 1'b1;
            ctl.incMode  = !opcode[0];
          end
          8'hF1: begin
            ctl.txSel = TX_STATUS;
            ctl.txIdx = phase ? 2'd0 : 2'd1;
          end
          8'hF2: begin
            if (cnt < 3'd3) begin
              ctl.txSel = TX_OFFSET;
              ctl.txIdx = cnt[1:0] + 2'd1;
            end
          end
          8'hF3: begin
            if (cnt == 3'd0) begin
              ctl.txSel = TX_TRACK;
              ctl.txIdx = 2'd1;
            end
          end
          8'hFF: ctl.txSel = TX_ECHO;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spiCmdDp.sv
module spiCmdDp
  import spiCmdPkg::*;
#(
  parameter logic [BYTE_W-1:0] TEST_TOKEN = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              readMode,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [BYTE_W-1:0] statusHiIn,
  input  logic [HALF_W-1:0] trackIn,
  input  logic [WORD_W-1:0] offsetIn,
  input  logic [BYTE_W-1:0] volumeIn,
  input  logic [BYTE_W-1:0] memRdData,
  output logic [BYTE_W-1:0] txByte,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [HALF_W-1:0] audioAddr,
  output logic [HALF_W-1:0] dataAddr,
  output logic [ADDR_W-1:0] romMask,
  output logic [ADDR_W-1:0] saveMask,
  output logic [2:0]        mapper,
  output logic              dmaGo,
  output logic              dmaPartial,
  output logic [1:0]        dmaTarget,
  output logic [HALF_W-1:0] dmaStart,
  output logic [HALF_W-1:0] dmaEnd,
  output logic [BYTE_W-1:0] volume,
  output logic              volStrobe,
  output logic              playing,
  output logic              ptrClear,
  output logic [BYTE_W-1:0] statusLo,
  output logic              memRd,
  output logic              memWr,
  output logic [BYTE_W-1:0] memWrData
);
  localparam int ACC_W = WORD_W - BYTE_W;

  logic [ACC_W-1:0]  acc;
  logic [WORD_W-1:0] accNext;
  logic [BYTE_W-1:0] txReg;
  logic [BYTE_W-1:0] txNext;
  logic              incQ;

  assign accNext = {acc, rxByte};
  assign txByte  = readMode ? memRdData : txReg;

  always_comb begin
    unique case (ctl.txSel)
      TX_TOKEN:  txNext = TEST_TOKEN;
      TX_STATUS: txNext = (ctl.txIdx == 2'd0) ? statusHiIn : statusLo;
      TX_OFFSET: txNext = offsetIn[(3 - ctl.txIdx) * BYTE_W +: BYTE_W];
      TX_TRACK:  txNext = (ctl.txIdx == 2'd0) ? trackIn[15:8] : trackIn[7:0];
      TX_VOLUME: txNext = volumeIn;
      TX_ECHO:   txNext = rxByte;
      default:   txNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc        <= '0;
      txReg      <= '0;
      ramAddr    <= '0;
      audioAddr  <= '0;
      dataAddr   <= '0;
      romMask    <= '0;
      saveMask   <= '0;
      mapper     <= '0;
      dmaGo      <= 1'b0;
      dmaPartial <= 1'b0;
      dmaTarget  <= '0;
      dmaStart   <= '0;
      dmaEnd     <= '0;
      volume     <= '0;
      volStrobe  <= 1'b0;
      playing    <= 1'b0;
      ptrClear   <= 1'b0;
      statusLo   <= '0;
      memRd      <= 1'b0;
      memWr      <= 1'b0;
      memWrData  <= '0;
      incQ       <= 1'b0;
    end else begin
      dmaGo     <= ctl.kickDma;
      volStrobe <= ctl.setVolume;
      ptrClear  <= ctl.ptrZero;
      memRd     <= ctl.memRead;
      memWr     <= ctl.memWrite;
      incQ      <= ctl.incMode;
      if (ctl.accShift) acc <= accNext[ACC_W-1:0];
      if (ctl.txLoad) txReg <= txNext;
      if (ctl.memWrite) memWrData <= rxByte;
      if (ctl.setRamAddr) ramAddr <= accNext[ADDR_W-1:0];
      else if ((memRd || memWr) && incQ) ramAddr <= ramAddr + 1'b1;
      if (ctl.setAudioAddr) audioAddr <= accNext[HALF_W-1:0];
      if (ctl.setDataAddr) dataAddr <= accNext[HALF_W-1:0];
      if (ctl.setRomMask) romMask <= accNext[ADDR_W-1:0];
      if (ctl.setSaveMask) saveMask <= accNext[ADDR_W-1:0];
      if (ctl.setMapper) mapper <= rxByte[2:0];
      if (ctl.kickDma) begin
        dmaPartial <= rxByte[2];
        dmaTarget  <= rxByte[1:0];
      end
      if (ctl.setWindow) begin
        dmaStart <= accNext[WORD_W-1:HALF_W];
        dmaEnd   <= accNext[HALF_W-1:0];
      end
      if (ctl.setVolume) volume <= accNext[23:16];
      if (ctl.setStatus) statusLo <= (statusLo | accNext[15:8]) & ~accNext[7:0];
      if (ctl.playOn) playing <= 1'b1;
      else if (ctl.playOff) playing <= 1'b0;
    end
  end
endmodule

// File: rtl/spiCmdDecoder.sv
module spiCmdDecoder
  import spiCmdPkg::*;
#(
  parameter logic [7:0] TEST_TOKEN = 8'hA5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csActive,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  output logic [7:0]  txByte,
  output logic [23:0] ramAddr,
  output logic [15:0] audioAddr,
  output logic [15:0] dataAddr,
  output logic [23:0] romMask,
  output logic [23:0] saveMask,
  output logic [2:0]  mapper,
  output logic        dmaGo,
  output logic        dmaPartial,
  output logic [1:0]  dmaTarget,
  output logic [15:0] dmaStart,
  output logic [15:0] dmaEnd,
  output logic [7:0]  volume,
  output logic        volStrobe,
  output logic        playing,
  output logic        ptrClear,
  output logic [7:0]  statusLo,
  input  logic [7:0]  statusHiIn,
  input  logic [15:0] trackIn,
  input  logic [31:0] offsetIn,
  input  logic [7:0]  volumeIn,
  output logic        memRd,
  output logic        memWr,
  output logic [7:0]  memWrData,
  input  logic [7:0]  memRdData
);
  ctlStrobes_t ctl;
  logic        readMode;

  spiCmdCtl uCtl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .rxValid(rxValid),
    .rxByte(rxByte), .ctl(ctl), .readMode(readMode)
  );

  spiCmdDp #(.TEST_TOKEN(TEST_TOKEN)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .readMode(readMode), .rxByte(rxByte),
    .statusHiIn(statusHiIn), .trackIn(trackIn), .offsetIn(offsetIn),
    .volumeIn(volumeIn), .memRdData(memRdData), .txByte(txByte),
    .ramAddr(ramAddr), .audioAddr(audioAddr), .dataAddr(dataAddr),
    .romMask(romMask), .saveMask(saveMask), .mapper(mapper), .dmaGo(dmaGo),
    .dmaPartial(dmaPartial), .dmaTarget(dmaTarget), .dmaStart(dmaStart),
    .dmaEnd(dmaEnd), .volume(volume), .volStrobe(volStrobe),
    .playing(playing), .ptrClear(ptrClear), .statusLo(statusLo),
    .memRd(memRd), .memWr(memWr), .memWrData(memWrData)
  );
endmodule

// File: rtl/spiCmdChk.sv
module spiCmdChk (
  input logic        clk,
  input logic        rstN,
  input logic        csActive,
  input logic        rxValid,
  input logic        dmaGo,
  input logic        volStrobe,
  input logic        ptrClear,
  input logic        memRd,
  input logic        memWr,
  input logic [7:0]  volume,
  input logic [7:0]  statusLo,
  input logic [15:0] audioAddr
);
  // R4
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaGo |=> !dmaGo);
  // R8
  ptr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptrClear |=> !ptrClear);
  // R6
  vol_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(volume) |-> volStrobe);
  // R11
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  // R12
  status_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusLo) |-> $past(csActive && rxValid));
  // R2
  audio_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(audioAddr) |-> $past(csActive && rxValid));
endmodule

bind spiCmdDecoder spiCmdChk uChk (
  .clk(clk), .rstN(rstN), .csActive(csActive), .rxValid(rxValid),
  .dmaGo(dmaGo), .volStrobe(volStrobe), .ptrClear(ptrClear), .memRd(memRd),
  .memWr(memWr), .volume(volume), .statusLo(statusLo), .audioAddr(audioAddr)
);

// File: tb/tb_spiCmdDecoder.sv
module tb_spiCmdDecoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csActive = 1'b0, rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic [7:0] statusHiIn = '0, volumeIn = '0;
  logic [15:0] trackIn = '0;
  logic [31:0] offsetIn = '0;
  logic [7:0] memRdData = '0;
  logic [7:0] txByte, volume, statusLo, memWrData;
  logic [23:0] ramAddr, romMask, saveMask;
  logic [15:0] audioAddr, dataAddr, dmaStart, dmaEnd;
  logic [2:0] mapper;
  logic [1:0] dmaTarget;
  logic dmaGo, dmaPartial, volStrobe, playing, ptrClear, memRd, memWr;

  int total = 0, bad = 0;
  int dmaCnt = 0, volCnt = 0, ptrCnt = 0, wrCnt = 0;
  logic [23:0] lastWrAddr = '0;
  logic [7:0] lastWrData = '0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic sampleReq = 1'b0;

  always #10 clk = ~clk;

  spiCmdDecoder dut (
    .clk(clk), .rstN(rstN), .csActive(csActive), .rxValid(rxValid),
    .rxByte(rxByte), .txByte(txByte), .ramAddr(ramAddr), .audioAddr(audioAddr),
    .dataAddr(dataAddr), .romMask(romMask), .saveMask(saveMask),
    .mapper(mapper), .dmaGo(dmaGo), .dmaPartial(dmaPartial),
    .dmaTarget(dmaTarget), .dmaStart(dmaStart), .dmaEnd(dmaEnd),
    .volume(volume), .volStrobe(volStrobe), .playing(playing),
    .ptrClear(ptrClear), .statusLo(statusLo), .statusHiIn(statusHiIn),
    .trackIn(trackIn), .offsetIn(offsetIn), .volumeIn(volumeIn),
    .memRd(memRd), .memWr(memWr), .memWrData(memWrData),
    .memRdData(memRdData)
  );

  // memory model and strobe counters
  always @(posedge clk) begin
    if (memRd) memRdData <= ramAddr[7:0] ^ 8'h3C;
    if (memWr) begin
      wrCnt <= wrCnt + 1;
      lastWrAddr <= ramAddr;
      lastWrData <= memWrData;
    end
    if (dmaGo) dmaCnt <= dmaCnt + 1;
    if (volStrobe) volCnt <= volCnt + 1;
    if (ptrClear) ptrCnt <= ptrCnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares each reply byte against the scoreboard queue
  always @(negedge clk) begin
    if (sampleReq) begin
      check(tagQ.pop_front(), {24'h0, txByte}, {24'h0, expQ.pop_front()});
      sampleReq <= 1'b0;
    end
  end

  task automatic csOn();
    @(negedge clk); csActive = 1'b1;
  endtask

  task automatic csOff();
    @(negedge clk); csActive = 1'b0;
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic [7:0] expReply, input string req);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
    @(posedge clk); #2;
    expQ.push_back(expReply);
    tagQ.push_back({req, " reply"});
    sampleReq = 1'b1;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 txByte", {24'h0, txByte}, 32'h0);
    check("R1 ramAddr", {8'h0, ramAddr}, 32'h0);
    check("R1 strobes", {27'h0, dmaGo, volStrobe, ptrClear, memRd, memWr}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {16'h0, mapper, statusLo, playing, 4'h0}, 32'h0);

    // R2 address loads
    csOn(); sendByte(8'h00, 8'h00, "R2"); sendByte(8'h12, 8'h00, "R2");
    sendByte(8'h34, 8'h00, "R2");
    check("R2 ramAddr before last byte", {8'h0, ramAddr}, 32'h0);
    sendByte(8'h56, 8'h00, "R2"); csOff();
    check("R2 ramAddr", {8'h0, ramAddr}, 32'h123456);
    csOn(); sendByte(8'h01, 0, "R2"); sendByte(8'hAB, 0, "R2"); sendByte(8'hCD, 0, "R2"); csOff();
    check("R2 audioAddr", {16'h0, audioAddr}, 32'hABCD);
    csOn(); sendByte(8'h02, 0, "R2"); sendByte(8'h11, 0, "R2"); sendByte(8'h22, 0, "R2"); csOff();
    check("R2 dataAddr", {16'h0, dataAddr}, 32'h1122);

    // R3 masks
    csOn(); sendByte(8'h10, 0, "R3"); sendByte(8'h0F, 0, "R3"); sendByte(8'hFF, 0, "R3");
    sendByte(8'hFE, 0, "R3"); csOff();
    check("R3 romMask", {8'h0, romMask}, 32'h0FFFFE);
    csOn(); sendByte(8'h20, 0, "R3"); sendByte(8'h01, 0, "R3"); sendByte(8'hE0, 0, "R3");
    sendByte(8'h07, 0, "R3"); csOff();
    check("R3 saveMask", {8'h0, saveMask}, 32'h01E007);

    // R4 mapper and DMA start
    csOn(); sendByte(8'h37, 0, "R4"); csOff();
    check("R4 mapper", {29'h0, mapper}, 32'd7);
    csOn(); sendByte(8'h46, 0, "R4"); csOff();
    check("R4 dma count", dmaCnt, 32'd1);
    check("R4 dma flags", {29'h0, dmaPartial, dmaTarget}, 32'b110);

    // R5 window
    csOn(); sendByte(8'h60, 0, "R5"); sendByte(8'h01, 0, "R5"); sendByte(8'h00, 0, "R5");
    sendByte(8'h01, 0, "R5"); sendByte(8'h80, 0, "R5"); csOff();
    check("R5 window", {dmaStart, dmaEnd}, 32'h0100_0180);

    // R6 volume latched on second dummy
    csOn(); sendByte(8'h50, 0, "R6"); sendByte(8'h40, 0, "R6"); sendByte(8'h00, 0, "R6");
    check("R6 volume before latch", {24'h0, volume}, 32'h0);
    sendByte(8'h00, 0, "R6"); csOff();
    check("R6 volume", {24'h0, volume}, 32'h40);
    check("R6 strobe count", volCnt, 32'd1);

    // R7 status set/clear
    csOn(); sendByte(8'hE0, 0, "R7"); sendByte(8'hFF, 0, "R7"); sendByte(8'h00, 0, "R7"); csOff();
    check("R7 set", {24'h0, statusLo}, 32'hFF);
    csOn(); sendByte(8'hE0, 0, "R7"); sendByte(8'h00, 0, "R7"); sendByte(8'h0F, 0, "R7"); csOff();
    check("R7 clear", {24'h0, statusLo}, 32'hF0);
    csOn(); sendByte(8'hE0, 0, "R7"); sendByte(8'h03, 0, "R7"); sendByte(8'h03, 0, "R7"); csOff();
    check("R7 clear wins", {24'h0, statusLo}, 32'hF0);

    // R8 playback control
    csOn(); sendByte(8'hE2, 0, "R8"); csOff();
    check("R8 play", {31'h0, playing}, 32'd1);
    csOn(); sendByte(8'hE3, 0, "R8"); csOff();
    check("R8 ptr clear", ptrCnt, 32'd1);
    csOn(); sendByte(8'hE1, 0, "R8"); csOff();
    check("R8 pause", {31'h0, playing}, 32'd0);

    // R9 readback
    statusHiIn = 8'hC3; trackIn = 16'h0102; offsetIn = 32'hDEADBEEF; volumeIn = 8'h77;
    csOn(); sendByte(8'hF0, 8'hA5, "R9 token"); sendByte(8'h00, 8'h00, "R9 token tail"); csOff();
    csOn(); sendByte(8'hF1, 8'hC3, "R9 status"); sendByte(8'h00, 8'hF0, "R9 status");
    sendByte(8'h00, 8'hC3, "R9 status"); sendByte(8'h00, 8'hF0, "R9 status"); csOff();
    csOn(); sendByte(8'hF2, 8'hDE, "R9 offset"); sendByte(8'h00, 8'hAD, "R9 offset");
    sendByte(8'h00, 8'hBE, "R9 offset"); sendByte(8'h00, 8'hEF, "R9 offset");
    sendByte(8'h00, 8'h00, "R9 offset tail"); csOff();
    csOn(); sendByte(8'hF3, 8'h01, "R9 track"); sendByte(8'h00, 8'h02, "R9 track");
    sendByte(8'h00, 8'h00, "R9 track tail"); csOff();
    csOn(); sendByte(8'hF4, 8'h77, "R9 volume"); sendByte(8'h00, 8'h00, "R9 volume tail"); csOff();

    // R10 echo
    csOn(); sendByte(8'hFF, 8'h00, "R10"); sendByte(8'h5A, 8'h5A, "R10");
    sendByte(8'h3C, 8'h3C, "R10"); csOff();

    // R11 memory access
    csOn(); sendByte(8'h00, 0, "R11"); sendByte(8'h00, 0, "R11"); sendByte(8'h00, 0, "R11");
    sendByte(8'h10, 0, "R11"); csOff();
    csOn(); sendByte(8'h80, 8'h2C, "R11 read inc"); sendByte(8'h00, 8'h2D, "R11 read inc");
    sendByte(8'h00, 8'h2E, "R11 read inc"); csOff();
    check("R11 addr after inc reads", {8'h0, ramAddr}, 32'h13);
    csOn(); sendByte(8'h81, 8'h2F, "R11 read hold"); sendByte(8'h00, 8'h2F, "R11 read hold"); csOff();
    check("R11 addr after hold reads", {8'h0, ramAddr}, 32'h13);
    csOn(); sendByte(8'h90, 0, "R11"); sendByte(8'hAA, 0, "R11"); sendByte(8'hBB, 0, "R11"); csOff();
    check("R11 write count", wrCnt, 32'd2);
    check("R11 last write", {lastWrAddr, lastWrData}, 32'h0000_14BB);
    check("R11 addr after inc writes", {8'h0, ramAddr}, 32'h15);
    csOn(); sendByte(8'h91, 0, "R11"); sendByte(8'hCC, 0, "R11"); csOff();
    check("R11 hold write", {lastWrAddr, lastWrData}, 32'h0000_15CC);
    check("R11 addr after hold write", {8'h0, ramAddr}, 32'h15);

    // R12 abort on chip select drop
    csOn(); sendByte(8'h00, 0, "R12"); sendByte(8'h77, 0, "R12"); sendByte(8'h66, 0, "R12"); csOff();
    csOn(); sendByte(8'h31, 0, "R12"); csOff();
    check("R12 ramAddr kept", {8'h0, ramAddr}, 32'h15);
    check("R12 next opcode decoded", {29'h0, mapper}, 32'd1);
    csOn(); sendByte(8'hE0, 0, "R12"); sendByte(8'h0F, 0, "R12"); csOff();
    check("R12 status kept", {24'h0, statusLo}, 32'hF0);

    // R13 unknown opcode
    csOn(); sendByte(8'h70, 8'h00, "R13"); sendByte(8'h11, 8'h00, "R13");
    sendByte(8'h22, 8'h00, "R13"); sendByte(8'h33, 8'h00, "R13"); csOff();
    check("R13 regs kept", {romMask[7:0], statusLo, 5'h0, mapper, 8'h0}, 32'hFEF0_0100);

    // R14 surplus bytes
    csOn(); sendByte(8'h01, 0, "R14"); sendByte(8'h33, 0, "R14"); sendByte(8'h44, 0, "R14");
    sendByte(8'h55, 0, "R14"); csOff();
    check("R14 audioAddr", {16'h0, audioAddr}, 32'h3344);
    csOn(); sendByte(8'h32, 0, "R14"); sendByte(8'h35, 0, "R14"); sendByte(8'h46, 0, "R14"); csOff();
    check("R14 mapper", {29'h0, mapper}, 32'd2);
    check("R14 no dma", dmaCnt, 32'd1);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule